// File: doc/BRIEF.md
# Eight-Point Low-Harmonic Transform Engine

This block turns one period of eight equally spaced, already averaged baseband samples into the DC term and the complex value (real and imaginary part) of harmonics 1, 2 and 3 of the fundamental. It evaluates only bins 0 to 3 of an eight-point discrete Fourier transform on real input. One shared multiplier does all the work in a fixed schedule. Eight multiply-accumulate steps build each output word. One more step then multiplies the sum by a correction gain for that bin. This gain undoes the sinc-shaped droop that the sampling mixer imposes on each harmonic.

A baseband controller presents the packed sample vector and pulses `start` while the engine is idle. It then waits for the one-cycle `done` pulse, at which point all seven result words are valid. They hold until the next accepted start. The four correction gains are signed Q2.14 registers written through a small write port. One instance serves one channel, so a two-channel front end places two instances.

Top module: `dft8_harm_engine`

## Requirements
- R1: After reset `done` is low, all seven result outputs are zero and all four gains equal 1.0 (code 16384).
- R2: A `start` seen high at a clock edge while idle is accepted. `done` goes high 63 clock cycles after that edge, stays high for exactly one cycle, and the engine is idle again in that cycle, so a start held high is accepted at the next edge.
- R3: `dc_out` equals the sum of the eight samples times gain 0. Sample n sits at `samp_vec[10n+9:10n]` in two's complement.
- R4: For harmonic k, the real output is the sum of x[n]·cos(2πkn/8) and the imaginary output is the negated sum of x[n]·sin(2πkn/8). Each output is then multiplied by gain k. The twiddles are quantised to Q1.15, with ±1 as ±32768, ±√2/2 as ±23170, and 0.
- R5: A write with `gain_we` high stores `gain_data` (signed Q2.14) into gain `gain_sel` (0 = DC, 1 to 3 = harmonic). The new value applies to every transform accepted after the write edge.
- R6: Every result equals floor((A·g + 2^24) / 2^25), where A is the twiddle-weighted sum and g the gain code. This gives 4 fractional bits. The result saturates to the 18-bit range −131072 to 131071.
- R7: A `start` seen while a transform runs is ignored. The running transform keeps its samples, its results and its `done` timing, and no extra `done` follows.
- R8: While idle with `start` low, all result outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a transform of `samp_vec` |
| samp_vec | input | 80 | Eight signed 10-bit samples, sample n in bits 10n+9:10n |
| gain_we | input | 1 | Gain write enable |
| gain_sel | input | 2 | Gain index to write |
| gain_data | input | 16 | Gain value, signed Q2.14 |
| dc_out | output | 18 | DC result, signed, 4 fractional bits |
| h1_re | output | 18 | Harmonic 1 real part |
| h1_im | output | 18 | Harmonic 1 imaginary part |
| h2_re | output | 18 | Harmonic 2 real part |
| h2_im | output | 18 | Harmonic 2 imaginary part |
| h3_re | output | 18 | Harmonic 3 real part |
| h3_im | output | 18 | Harmonic 3 imaginary part |
| done | output | 1 | One-cycle pulse when all results are valid |

## Verification
The properties assume that `start` is the only thing that opens a transform. They also assume that the gain registers are written only while the engine is idle, because a write during a run would reach the words scaled after it. The stimulus issues gain writes only between transforms. It never combines a write with a start in the same cycle. It does drive `start` freely during runs and holds it high across back-to-back runs, so the ignore rule and the re-accept at the `done` cycle are exercised.

// File: rtl/dft8_pkg.sv
package dft8_pkg;

   localparam int NPTS      = 8;
   localparam int NBINS     = 4;
   localparam int NWORDS    = 2 * NBINS - 1;
   localparam int COEF_W    = 17;
   localparam int COEF_FRAC = 15;

   localparam logic signed [COEF_W-1:0] K_UNIT = 17'sd32768;
   localparam logic signed [COEF_W-1:0] K_HALF_RT2 = 17'sd23170;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_MAC  = 2'd1,
      ST_SCL  = 2'd2
   } seq_state_t;

   // cosine of (ph * pi / 4) in Q1.15
   function automatic logic signed [COEF_W-1:0] cos_q15(input logic [2:0] ph);
      logic signed [COEF_W-1:0] c;
      case (ph)
         3'd0:        c = K_UNIT;
         3'd1, 3'd7:  c = K_HALF_RT2;
         3'd3, 3'd5:  c = -K_HALF_RT2;
         3'd4:        c = -K_UNIT;
         default:     c = '0;
      endcase
      return c;
   endfunction

   // output word order: DC, re1, im1, re2, im2, re3, im3
   function automatic logic [1:0] word_bin(input logic [2:0] w);
      return w[2:1] + {1'b0, w[0]};
   endfunction

   function automatic logic word_is_im(input logic [2:0] w);
      return (w != 3'd0) && !w[0];
   endfunction

endpackage

// File: rtl/dft8_seq.sv
module dft8_seq
   import dft8_pkg::*;
#(
   parameter int N_SAMP = 8,
   parameter int N_WORD = 7
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start,
   output logic                      idle,
   output logic                      acc_en,
   output logic                      scale,
   output logic                      word_we,
   output logic [$clog2(N_SAMP)-1:0] samp_idx,
   output logic [$clog2(N_WORD)-1:0] word_idx,
   output logic                      done
);

   localparam int S_W = $clog2(N_SAMP);
   localparam int W_W = $clog2(N_WORD);
   localparam logic [S_W-1:0] S_LAST = S_W'(N_SAMP - 1);
   localparam logic [W_W-1:0] W_LAST = W_W'(N_WORD - 1);

   if (N_SAMP < 2) begin : g_bad_samp
      $error("dft8_seq: N_SAMP must be at least 2");
   end
   if (N_WORD < 2) begin : g_bad_word
      $error("dft8_seq: N_WORD must be at least 2");
   end

   seq_state_t       state;
   logic [S_W-1:0]   s_cnt;
   logic [W_W-1:0]   w_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         s_cnt <= '0;
         w_cnt <= '0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start) begin
                  state <= ST_MAC;
                  s_cnt <= '0;
                  w_cnt <= '0;
               end
            end
            ST_MAC: begin
               if (s_cnt == S_LAST) begin
                  s_cnt <= '0;
                  state <= ST_SCL;
               end else begin
                  s_cnt <= s_cnt + 1'b1;
               end
            end
            ST_SCL: begin
               if (w_cnt == W_LAST) begin
                  state <= ST_IDLE;
                  done  <= 1'b1;
               end else begin
                  w_cnt <= w_cnt + 1'b1;
                  state <= ST_MAC;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign idle     = (state == ST_IDLE);
   assign acc_en   = (state == ST_MAC);
   assign scale    = (state == ST_SCL);
   assign word_we  = (state == ST_SCL);
   assign samp_idx = s_cnt;
   assign word_idx = w_cnt;

endmodule

// File: rtl/dft8_gain_bank.sv
module dft8_gain_bank #(
   parameter int N_GAIN    = 4,
   parameter int GAIN_W    = 16,
   parameter int GAIN_FRAC = 14
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [$clog2(N_GAIN)-1:0] wr_sel,
   input  logic [GAIN_W-1:0]         wr_data,
   input  logic [$clog2(N_GAIN)-1:0] rd_sel,
   output logic signed [GAIN_W-1:0]  rd_gain
);

   localparam int SEL_W = $clog2(N_GAIN);
   localparam logic [GAIN_W-1:0] G_UNITY = GAIN_W'(1) << GAIN_FRAC;

   if (GAIN_FRAC >= GAIN_W - 1) begin : g_bad_frac
      $error("dft8_gain_bank: gain needs at least one integer bit above the sign");
   end

   logic [GAIN_W-1:0] gain_q [N_GAIN];

   for (genvar b = 0; b < N_GAIN; b++) begin : g_gain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            gain_q[b] <= G_UNITY;
         end else if (wr_en && (wr_sel == SEL_W'(b))) begin
            gain_q[b] <= wr_data;
         end
      end
   end

   assign rd_gain = $signed(gain_q[rd_sel]);

endmodule

// File: rtl/dft8_mac.sv
module dft8_mac
   import dft8_pkg::*;
#(
   parameter int DATA_W    = 10,
   parameter int GAIN_W    = 16,
   parameter int GAIN_FRAC = 14,
   parameter int OUT_W     = 18,
   parameter int OUT_FRAC  = 4,
   parameter bit ROUND_EN  = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     acc_en,
   input  logic                     scale,
   input  logic signed [DATA_W-1:0] samp,
   input  logic signed [COEF_W-1:0] coef,
   input  logic signed [GAIN_W-1:0] gain,
   output logic signed [OUT_W-1:0]  result
);

   localparam int ACC_W  = DATA_W + COEF_W + $clog2(NPTS);
   localparam int MB_W   = (GAIN_W > COEF_W) ? GAIN_W : COEF_W;
   localparam int PROD_W = ACC_W + MB_W;
   localparam int SUM_W  = PROD_W + 1;
   localparam int SHIFT  = COEF_FRAC + GAIN_FRAC - OUT_FRAC;

   localparam logic signed [SUM_W-1:0] SAT_HI =
      {{(SUM_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
   localparam logic signed [SUM_W-1:0] SAT_LO =
      {{(SUM_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

   if (SHIFT < 1) begin : g_bad_shift
      $error("dft8_mac: OUT_FRAC leaves no bits to discard");
   end
   if (OUT_W < 2 || OUT_W >= SUM_W - SHIFT) begin : g_bad_out
      $error("dft8_mac: OUT_W out of range");
   end

   logic signed [ACC_W-1:0]  acc_q;
   logic signed [PROD_W-1:0] a_x, b_x, prod;
   logic signed [SUM_W-1:0]  sum, shifted;

   // operand selection for the single shared multiplier
   always_comb begin
      if (scale) begin
         a_x = {{(PROD_W-ACC_W){acc_q[ACC_W-1]}}, acc_q};
         b_x = {{(PROD_W-GAIN_W){gain[GAIN_W-1]}}, gain};
      end else begin
         a_x = {{(PROD_W-DATA_W){samp[DATA_W-1]}}, samp};
         b_x = {{(PROD_W-COEF_W){coef[COEF_W-1]}}, coef};
      end
   end

   assign prod = a_x * b_x;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
      end else if (scale) begin
         acc_q <= '0;
      end else if (acc_en) begin
         acc_q <= acc_q + prod[ACC_W-1:0];
      end
   end

   if (ROUND_EN) begin : g_round
      localparam logic signed [SUM_W-1:0] HALF = {{(SUM_W-1){1'b0}}, 1'b1} << (SHIFT - 1);
      assign sum = {prod[PROD_W-1], prod} + HALF;
   end else begin : g_trunc
      assign sum = {prod[PROD_W-1], prod};
   end

   assign shifted = sum >>> SHIFT;

   always_comb begin
      if (shifted > SAT_HI) begin
         result = SAT_HI[OUT_W-1:0];
      end else if (shifted < SAT_LO) begin
         result = SAT_LO[OUT_W-1:0];
      end else begin
         result = shifted[OUT_W-1:0];
      end
   end

endmodule

// File: rtl/dft8_harm_engine.sv
module dft8_harm_engine
   import dft8_pkg::*;
#(
   parameter int DATA_W    = 10,
   parameter int GAIN_W    = 16,
   parameter int GAIN_FRAC = 14,
   parameter int OUT_W     = 18,
   parameter int OUT_FRAC  = 4,
   parameter bit ROUND_EN  = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic [NPTS*DATA_W-1:0]   samp_vec,
   input  logic                     gain_we,
   input  logic [1:0]               gain_sel,
   input  logic [GAIN_W-1:0]        gain_data,
   output logic signed [OUT_W-1:0]  dc_out,
   output logic signed [OUT_W-1:0]  h1_re,
   output logic signed [OUT_W-1:0]  h1_im,
   output logic signed [OUT_W-1:0]  h2_re,
   output logic signed [OUT_W-1:0]  h2_im,
   output logic signed [OUT_W-1:0]  h3_re,
   output logic signed [OUT_W-1:0]  h3_im,
   output logic                     done
);

   localparam int VEC_W = NPTS * DATA_W;
   localparam int S_W   = $clog2(NPTS);
   localparam int W_W   = $clog2(NWORDS);

   if (DATA_W < 2) begin : g_bad_data
      $error("dft8_harm_engine: DATA_W must be at least 2");
   end
   if (NBINS != 4) begin : g_bad_bins
      $error("dft8_harm_engine: gain select width assumes four bins");
   end

   logic              seq_idle, acc_en, scale, word_we, capture;
   logic [S_W-1:0]    samp_idx;
   logic [W_W-1:0]    word_idx;
   logic [VEC_W-1:0]  samp_q;
   logic [1:0]        bin;
   logic              is_im;
   logic [2:0]        ph_kn, ph_tw;
   logic signed [COEF_W-1:0] coef;
   logic signed [GAIN_W-1:0] gain;
   logic signed [DATA_W-1:0] samp_cur;
   logic signed [OUT_W-1:0]  mac_res;
   logic signed [OUT_W-1:0]  res_q [NWORDS];

   dft8_seq #(
      .N_SAMP (NPTS),
      .N_WORD (NWORDS)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .idle     (seq_idle),
      .acc_en   (acc_en),
      .scale    (scale),
      .word_we  (word_we),
      .samp_idx (samp_idx),
      .word_idx (word_idx),
      .done     (done)
   );

   assign capture = seq_idle & start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         samp_q <= '0;
      end else if (capture) begin
         samp_q <= samp_vec;
      end
   end

   // twiddle phase index: (k*n) mod 8, shifted by a quarter turn for -sin
   assign bin      = word_bin(word_idx);
   assign is_im    = word_is_im(word_idx);
   assign ph_kn    = {1'b0, bin} * samp_idx;
   assign ph_tw    = is_im ? (ph_kn + 3'd2) : ph_kn;
   assign coef     = cos_q15(ph_tw);
   assign samp_cur = $signed(samp_q[samp_idx*DATA_W +: DATA_W]);

   dft8_gain_bank #(
      .N_GAIN    (NBINS),
      .GAIN_W    (GAIN_W),
      .GAIN_FRAC (GAIN_FRAC)
   ) u_gain (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (gain_we),
      .wr_sel  (gain_sel),
      .wr_data (gain_data),
      .rd_sel  (bin),
      .rd_gain (gain)
   );

   dft8_mac #(
      .DATA_W    (DATA_W),
      .GAIN_W    (GAIN_W),
      .GAIN_FRAC (GAIN_FRAC),
      .OUT_W     (OUT_W),
      .OUT_FRAC  (OUT_FRAC),
      .ROUND_EN  (ROUND_EN)
   ) u_mac (
      .clk    (clk),
      .rst_n  (rst_n),
      .acc_en (acc_en),
      .scale  (scale),
      .samp   (samp_cur),
      .coef   (coef),
      .gain   (gain),
      .result (mac_res)
   );

   for (genvar w = 0; w < NWORDS; w++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            res_q[w] <= '0;
         end else if (word_we && (word_idx == W_W'(w))) begin
            res_q[w] <= mac_res;
         end
      end
   end

   assign dc_out = res_q[0];
   assign h1_re  = res_q[1];
   assign h1_im  = res_q[2];
   assign h2_re  = res_q[3];
   assign h2_im  = res_q[4];
   assign h3_re  = res_q[5];
   assign h3_im  = res_q[6];

endmodule

// File: rtl/dft8_harm_chk.sv
module dft8_harm_chk #(
   parameter int OUT_W    = 18,
   parameter int VEC_W    = 80,
   parameter int LAT_DONE = 64
) (
   input logic               clk,
   input logic               rst_n,
   input logic               start,
   input logic               done,
   input logic               idle,
   input logic [VEC_W-1:0]   samp_q,
   input logic [7*OUT_W-1:0] outs
);

   if (LAT_DONE >= 255) begin : g_bad_lat
      $error("dft8_harm_chk: latency window exceeds counter");
   end

   // cycles since the last accepted start (1 in the cycle after acceptance)
   logic [7:0] lat;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat <= '0;
      end else if (start && idle) begin
         lat <= 8'd1;
      end else if (lat != 8'd0 && lat != 8'hFF) begin
         lat <= lat + 8'd1;
      end
   end

   p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> idle);

   p_done_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (lat == 8'(LAT_DONE)));

   p_busy_keeps_samples_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !idle |=> $stable(samp_q));

   p_idle_holds_results_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && !start) |=> $stable(outs));

endmodule

bind dft8_harm_engine dft8_harm_chk #(
   .OUT_W    (OUT_W),
   .VEC_W    (dft8_pkg::NPTS * DATA_W),
   .LAT_DONE ((dft8_pkg::NPTS + 1) * dft8_pkg::NWORDS + 1)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .start  (start),
   .done   (done),
   .idle   (seq_idle),
   .samp_q (samp_q),
   .outs   ({h3_im, h3_re, h2_im, h2_re, h1_im, h1_re, dc_out})
);

// File: tb/dft8_harm_engine_tb.sv
`timescale 1ns/1ps
module dft8_harm_engine_tb;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [79:0]  samp_vec = '0;
   logic         gain_we = 1'b0;
   logic [1:0]   gain_sel = '0;
   logic [15:0]  gain_data = '0;
   logic signed [17:0] dc_out, h1_re, h1_im, h2_re, h2_im, h3_re, h3_im;
   logic         done;

   always #2.5 clk = ~clk;

   dft8_harm_engine u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .samp_vec  (samp_vec),
      .gain_we   (gain_we),
      .gain_sel  (gain_sel),
      .gain_data (gain_data),
      .dc_out    (dc_out),
      .h1_re     (h1_re),
      .h1_im     (h1_im),
      .h2_re     (h2_re),
      .h2_im     (h2_im),
      .h3_re     (h3_re),
      .h3_im     (h3_im),
      .done      (done)
   );

   int     n_cmp = 0;
   int     n_bad = 0;
   bit     wd_hit = 1'b0;
   string  ph = "R1";

   // reference model state
   int     mcnt = 0;
   bit     exp_done = 1'b0;
   longint exp_o [7];
   longint pend  [7];
   longint mg    [4];

   function automatic longint twid(int k, int n, bit im);
      real ang, c;
      ang = 2.0 * 3.14159265358979 * real'(k * n) / 8.0;
      c = im ? -$sin(ang) : $cos(ang);
      return longint'($floor(c * 32768.0 + 0.5));
   endfunction

   task automatic model_compute();
      for (int w = 0; w < 7; w++) begin
         int     k;
         bit     im;
         longint a, p, r;
         k  = (w + 1) / 2;
         im = (w > 0) && (w % 2 == 0);
         a  = 0;
         for (int n = 0; n < 8; n++)
            a += longint'($signed(samp_vec[n*10 +: 10])) * twid(k, n, im);
         p = a * mg[k];
         r = (p + (64'sd1 <<< 24)) >>> 25;
         if (r > 131071) r = 131071;
         if (r < -131072) r = -131072;
         pend[w] = r;
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         mcnt = 0;
         exp_done = 1'b0;
         for (int i = 0; i < 7; i++) exp_o[i] = 0;
         for (int i = 0; i < 4; i++) mg[i] = 16384;
      end else begin
         bit was_idle;
         was_idle = (mcnt == 0);
         exp_done = 1'b0;
         if (gain_we) mg[gain_sel] = longint'($signed(gain_data));
         if (!was_idle) begin
            mcnt--;
            if (mcnt == 0) begin
               exp_done = 1'b1;
               for (int i = 0; i < 7; i++) exp_o[i] = pend[i];
            end
         end else if (start) begin
            mcnt = 63;
            model_compute();
         end
      end
   end

   function automatic longint got_word(int w);
      case (w)
         0: return longint'(dc_out);
         1: return longint'(h1_re);
         2: return longint'(h1_im);
         3: return longint'(h2_re);
         4: return longint'(h2_im);
         5: return longint'(h3_re);
         default: return longint'(h3_im);
      endcase
   endfunction

   // compare every cycle, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !wd_hit) begin
         n_cmp++;
         if (done !== exp_done) begin
            n_bad++;
            $display("FAIL %s R2 done: got %0b expected %0b", ph, done, exp_done);
         end
         if (mcnt == 0) begin
            for (int w = 0; w < 7; w++) begin
               n_cmp++;
               if (got_word(w) != exp_o[w]) begin
                  n_bad++;
                  $display("FAIL %s %s word%0d: got %0d expected %0d", ph,
                           (w == 0) ? "R3" : "R4", w, got_word(w), exp_o[w]);
               end
            end
         end
      end
   end

   task automatic wait_idle();
      while (mcnt != 0) @(negedge clk);
   endtask

   task automatic run_vec(input logic [79:0] v);
      @(negedge clk);
      samp_vec = v;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_idle();
   endtask

   task automatic write_gain(input logic [1:0] sel, input logic [15:0] val);
      @(negedge clk);
      gain_we = 1'b1;
      gain_sel = sel;
      gain_data = val;
      @(negedge clk);
      gain_we = 1'b0;
   endtask

   function automatic logic [79:0] fill(int val);
      logic [79:0] v;
      for (int n = 0; n < 8; n++) v[n*10 +: 10] = 10'(val);
      return v;
   endfunction

   function automatic logic [79:0] tone(int k, real amp, bit use_sin);
      logic [79:0] v;
      for (int n = 0; n < 8; n++) begin
         real a;
         a = 2.0 * 3.14159265358979 * real'(k * n) / 8.0;
         v[n*10 +: 10] = 10'(int'($floor(amp * (use_sin ? $sin(a) : $cos(a)) + 0.5)));
      end
      return v;
   endfunction

   function automatic logic [79:0] rnd_vec();
      logic [79:0] v;
      for (int n = 0; n < 8; n++) v[n*10 +: 10] = 10'($urandom);
      return v;
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      wd_hit = 1'b1;
      n_bad++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd7));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state observed by the per-cycle compare
      ph = "R1";
      repeat (4) @(negedge clk);
      run_vec(rnd_vec());          // default unity gains, R1

      ph = "R3";
      run_vec(fill(100));
      run_vec(fill(-37));
      run_vec(80'h0123456789ABCDEF0123);

      ph = "R4";
      run_vec(tone(1, 400.0, 1'b0));
      run_vec(tone(2, 300.0, 1'b1));
      run_vec(tone(3, 250.0, 1'b0));
      for (int i = 0; i < 4; i++) run_vec(rnd_vec());

      ph = "R5";
      write_gain(2'd1, 16'd20000);
      write_gain(2'd2, 16'hE000);
      write_gain(2'd3, 16'h7FFF);
      write_gain(2'd0, 16'd12000);
      for (int i = 0; i < 3; i++) run_vec(rnd_vec());

      // R6: -512 everywhere with gain -2.0 drives DC to +131072 -> clipped
      ph = "R6";
      write_gain(2'd0, 16'h8000);
      run_vec(fill(-512));
      run_vec(fill(511));
      write_gain(2'd0, 16'h7FFF);
      run_vec(fill(-512));

      // R7: start pulses during a run must not disturb it
      ph = "R7";
      @(negedge clk);
      samp_vec = rnd_vec();
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (10) @(negedge clk);
      samp_vec = rnd_vec();
      start = 1'b1;
      repeat (5) @(negedge clk);
      start = 1'b0;
      samp_vec = fill(3);
      wait_idle();
      repeat (5) @(negedge clk);

      // R8: idle hold while inputs wander
      ph = "R8";
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         samp_vec = rnd_vec();
      end

      // R2: start held high gives back-to-back runs
      ph = "R2";
      @(negedge clk);
      start = 1'b1;
      for (int i = 0; i < 200; i++) begin
         samp_vec = rnd_vec();
         @(negedge clk);
      end
      start = 1'b0;
      wait_idle();
      repeat (3) @(negedge clk);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule